// File: doc/BRIEF.md
# External Bus Access Timing Sequencer

This block runs one access at a time on an asynchronous parallel memory bus split into several address areas. A request names an area, an address, a direction, write data and byte enables. The block then drives that area's chip select, the read or write strobe, the address and the outgoing data. It samples an active-low wait input and ends the access with a one-cycle done pulse that carries the captured read data.

Each area has three settings. The first picks a basic strobe length of two or three cycles. The second is a programmed wait of 0 to 7 cycles, which applies only to three-cycle areas. The third is a chip-select extension. The access length is the sum of the basic cycles, the programmed waits, the extension cycles and any cycles added by the external wait input. The extension adds a cycle before the strobe, a cycle after it, or both. The block copies an area's settings when it accepts a request, so a later change to them cannot disturb an access already under way.

Top module: `ext_bus_seq`

## Requirements
- R1: While `busy_o` is low, `req_i` high at a rising edge accepts the request. `busy_o` is then high from the next cycle through the last access cycle. A request presented while `busy_o` is high is ignored.
- R2: An area whose `cfg_three_i` bit is 0 holds the strobe for exactly 2 cycles. Its programmed wait and `wait_ni` have no effect.
- R3: An area whose `cfg_three_i` bit is 1 holds the strobe for 3 + W cycles. W is the 3-bit field `cfg_wait_i[3a+2:3a]` of area a.
- R4: In a three-cycle area, `wait_ni` is sampled only at the rising edge that ends the last programmed strobe cycle, and again at each added cycle. Every sample that reads low adds one strobe cycle. A low level in any earlier cycle is ignored.
- R5: The 2-bit field `cfg_csx_i[2a+1:2a]` of area a sets the chip-select extension. 0 adds no cycles. 1 adds one cycle after the strobe. 2 or 3 adds one cycle before the strobe and one after it. In these extra cycles chip select is low and both strobes are high.
- R6: For the whole access, only `cs_n_o[a]` of the accepted area a is low. `rd_n_o` goes low only in the strobe cycles of a read, and `wr_n_o` only in the strobe cycles of a write. The two strobes are never low together.
- R7: On a read, `din_i` is captured at the rising edge that ends the last strobe cycle. That value appears on `rdata_o` no later than the done cycle.
- R8: `addr_o`, `dout_o` and `be_n_o` stay stable while chip select is low. `be_n_o` is the inverse of the accepted `req_be_i`. `dout_en_o` is high for the whole of a write access and low otherwise.
- R9: `done_o` is high for exactly one cycle, in the cycle after the last access cycle. In that cycle `busy_o` is low and every chip select is high, and a new request can be accepted.
- R10: If any area configuration changes after a request is accepted, the access in progress keeps the timing it was accepted with.
- R11: During and straight after reset, all chip selects and strobes are high, and `busy_o`, `done_o` and `dout_en_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_three_i | input | N_AREA | Per area: 1 selects the three-cycle basic access |
| cfg_wait_i | input | 3*N_AREA | Per-area programmed wait count |
| cfg_csx_i | input | 2*N_AREA | Per-area chip-select extension |
| req_i | input | 1 | Access request |
| req_area_i | input | AIW | Area index |
| req_addr_i | input | AW | Address |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | DW | Write data |
| req_be_i | input | DW/8 | Byte-lane enables |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | Access complete pulse |
| rdata_o | output | DW | Captured read data |
| cs_n_o | output | N_AREA | Chip selects, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| addr_o | output | AW | Bus address |
| dout_o | output | DW | Outgoing bus data |
| dout_en_o | output | 1 | Outgoing data drive enable |
| be_n_o | output | DW/8 | Byte-lane strobes, active low |
| din_i | input | DW | Incoming bus data |
| wait_ni | input | 1 | External wait, active low |

## Verification
Two things can fall in the same cycle: the done pulse of one access and the acceptance of the next. The bench issues every new request in the done cycle of the one before it. It then checks that the next access begins exactly one cycle later, on the right chip select. A second overlap is a wait sample landing on the final programmed cycle. The bench holds `wait_ni` low for 0, 1 or 2 samples there, and also low in an earlier strobe cycle. It then compares the strobe length it measures with 3 + W plus the number of low samples, for every wait and extension setting in both area types.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
  localparam int unsigned PW_W  = 3;
  localparam int unsigned CSX_W = 2;
  localparam int unsigned CNT_W = 4;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LEAD  = 2'd1,
    PH_STRB  = 2'd2,
    PH_TRAIL = 2'd3
  } phase_e;

  typedef struct packed {
    logic             three;
    logic [PW_W-1:0]  pw;
    logic [CSX_W-1:0] csx;
  } area_cfg_t;
endpackage

// File: rtl/ebs_area_sel.sv
module ebs_area_sel
  import ebs_pkg::*;
#(
  parameter int unsigned N_AREA = 4,
  localparam int unsigned AIW = (N_AREA > 1) ? $clog2(N_AREA) : 1
) (
  input  logic [N_AREA-1:0]       three_i,
  input  logic [N_AREA*PW_W-1:0]  pw_i,
  input  logic [N_AREA*CSX_W-1:0] csx_i,
  input  logic [AIW-1:0]          area_i,
  output area_cfg_t               cfg_o
);
  area_cfg_t tbl [N_AREA];

  for (genvar a = 0; a < N_AREA; a++) begin : g_unpack
    assign tbl[a].three = three_i[a];
    assign tbl[a].pw    = pw_i[a*PW_W +: PW_W];
    assign tbl[a].csx   = csx_i[a*CSX_W +: CSX_W];
  end

  always_comb begin
    cfg_o = '0;
    if (32'(area_i) < N_AREA) cfg_o = tbl[area_i];
  end
endmodule

// File: rtl/ebs_fsm.sv
module ebs_fsm
  import ebs_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  area_cfg_t cfg_i,
  input  logic      wait_ni,
  output phase_e    ph_o,
  output logic      cap_o,
  output logic      done_o
);
  phase_e           ph_q;
  area_cfg_t        cfg_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ext_hold;

  // wait only honoured once programmed cycles are used up, three-cycle areas only
  assign ext_hold = cfg_q.three && !wait_ni;
  assign cap_o    = (ph_q == PH_STRB) && (cnt_q == '0) && !ext_hold;
  assign ph_o     = ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cfg_q  <= '0;
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (ph_q)
        PH_IDLE: if (start_i) begin
          cfg_q <= cfg_i;
          cnt_q <= cfg_i.three ? CNT_W'(2) + CNT_W'(cfg_i.pw) : CNT_W'(1);
          ph_q  <= cfg_i.csx[1] ? PH_LEAD : PH_STRB;
        end
        PH_LEAD: ph_q <= PH_STRB;
        PH_STRB: begin
          if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
          else if (!ext_hold) begin
            if (cfg_q.csx != '0) ph_q <= PH_TRAIL;
            else begin
              ph_q   <= PH_IDLE;
              done_o <= 1'b1;
            end
          end
        end
        PH_TRAIL: begin
          ph_q   <= PH_IDLE;
          done_o <= 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ebs_pin_drv.sv
module ebs_pin_drv
  import ebs_pkg::*;
#(
  parameter int unsigned N_AREA = 4,
  parameter int unsigned BEW    = 2,
  localparam int unsigned AIW = (N_AREA > 1) ? $clog2(N_AREA) : 1
) (
  input  phase_e            ph_i,
  input  logic [AIW-1:0]    area_i,
  input  logic              we_i,
  input  logic [BEW-1:0]    be_i,
  output logic [N_AREA-1:0] cs_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              dout_en_o,
  output logic [BEW-1:0]    be_n_o
);
  logic act, strb;

  assign act  = (ph_i != PH_IDLE);
  assign strb = (ph_i == PH_STRB);

  for (genvar a = 0; a < N_AREA; a++) begin : g_cs
    assign cs_n_o[a] = !(act && (32'(area_i) == a));
  end

  assign rd_n_o    = !(strb && !we_i);
  assign wr_n_o    = !(strb && we_i);
  assign dout_en_o = act && we_i;
  assign be_n_o    = act ? ~be_i : '1;
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ebs_pkg::*;
#(
  parameter int unsigned N_AREA = 4,
  parameter int unsigned AW     = 16,
  parameter int unsigned DW     = 16,
  localparam int unsigned AIW = (N_AREA > 1) ? $clog2(N_AREA) : 1,
  localparam int unsigned BEW = DW / 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_AREA-1:0]       cfg_three_i,
  input  logic [N_AREA*PW_W-1:0]  cfg_wait_i,
  input  logic [N_AREA*CSX_W-1:0] cfg_csx_i,
  input  logic                    req_i,
  input  logic [AIW-1:0]          req_area_i,
  input  logic [AW-1:0]           req_addr_i,
  input  logic                    req_we_i,
  input  logic [DW-1:0]           req_wdata_i,
  input  logic [BEW-1:0]          req_be_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [DW-1:0]           rdata_o,
  output logic [N_AREA-1:0]       cs_n_o,
  output logic                    rd_n_o,
  output logic                    wr_n_o,
  output logic [AW-1:0]           addr_o,
  output logic [DW-1:0]           dout_o,
  output logic                    dout_en_o,
  output logic [BEW-1:0]          be_n_o,
  input  logic [DW-1:0]           din_i,
  input  logic                    wait_ni
);
  area_cfg_t      sel_cfg;
  phase_e         ph;
  logic           cap, accept;
  logic [AIW-1:0] area_q;
  logic           we_q;
  logic [BEW-1:0] be_q;

  assign busy_o = (ph != PH_IDLE);
  assign accept = req_i && !busy_o;

  ebs_area_sel #(.N_AREA(N_AREA)) u_sel (
    .three_i(cfg_three_i), .pw_i(cfg_wait_i), .csx_i(cfg_csx_i),
    .area_i(req_area_i), .cfg_o(sel_cfg)
  );

  ebs_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(accept), .cfg_i(sel_cfg),
    .wait_ni(wait_ni), .ph_o(ph), .cap_o(cap), .done_o(done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      area_q  <= '0;
      we_q    <= 1'b0;
      be_q    <= '0;
      addr_o  <= '0;
      dout_o  <= '0;
      rdata_o <= '0;
    end else begin
      if (accept) begin
        area_q <= req_area_i;
        we_q   <= req_we_i;
        be_q   <= req_be_i;
        addr_o <= req_addr_i;
        dout_o <= req_wdata_i;
      end
      if (cap && !we_q) rdata_o <= din_i;
    end
  end

  ebs_pin_drv #(.N_AREA(N_AREA), .BEW(BEW)) u_pins (
    .ph_i(ph), .area_i(area_q), .we_i(we_q), .be_i(be_q),
    .cs_n_o(cs_n_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o),
    .dout_en_o(dout_en_o), .be_n_o(be_n_o)
  );
endmodule

// File: rtl/ebs_chk.sv
module ebs_chk #(
  parameter int unsigned N_AREA = 4,
  parameter int unsigned AW     = 16,
  parameter int unsigned DW     = 16,
  localparam int unsigned BEW = DW / 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [N_AREA-1:0] cs_n_o,
  input logic              rd_n_o,
  input logic              wr_n_o,
  input logic [AW-1:0]     addr_o,
  input logic [DW-1:0]     dout_o,
  input logic [BEW-1:0]    be_n_o,
  input logic              dout_en_o
);
  assert_one_cs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o));

  assert_strobe_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n_o && !wr_n_o));

  assert_strobe_in_cs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_n_o || !wr_n_o) |-> (cs_n_o != '1));

  assert_accept_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o) |=> busy_o);

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && (cs_n_o == '1)));

  assert_bus_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(addr_o) && $stable(dout_o) && $stable(be_n_o)));

  assert_drive_in_access_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_en_o |-> busy_o);
endmodule

bind ext_bus_seq ebs_chk #(.N_AREA(N_AREA), .AW(AW), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .busy_o(busy_o),
  .done_o(done_o), .cs_n_o(cs_n_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o),
  .addr_o(addr_o), .dout_o(dout_o), .be_n_o(be_n_o), .dout_en_o(dout_en_o)
);

// File: tb/tb_ext_bus_seq.sv
module tb_ext_bus_seq;
  localparam int N_AREA = 4;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int BEW = DW / 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [N_AREA-1:0]   cfg_three = '0;
  logic [N_AREA*3-1:0] cfg_wait = '0;
  logic [N_AREA*2-1:0] cfg_csx = '0;
  logic req = 1'b0, we = 1'b0, wait_n = 1'b1;
  logic [1:0] area = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, din = '0;
  logic [BEW-1:0] be = '0;
  logic busy, done, rd_n, wr_n, dout_en;
  logic [DW-1:0] rdata, dout;
  logic [N_AREA-1:0] cs_n;
  logic [AW-1:0] addr_bus;
  logic [BEW-1:0] be_n;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #5 clk = ~clk;

  ext_bus_seq #(.N_AREA(N_AREA), .AW(AW), .DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_three_i(cfg_three), .cfg_wait_i(cfg_wait),
    .cfg_csx_i(cfg_csx), .req_i(req), .req_area_i(area), .req_addr_i(addr),
    .req_we_i(we), .req_wdata_i(wdata), .req_be_i(be), .busy_o(busy),
    .done_o(done), .rdata_o(rdata), .cs_n_o(cs_n), .rd_n_o(rd_n), .wr_n_o(wr_n),
    .addr_o(addr_bus), .dout_o(dout), .dout_en_o(dout_en), .be_n_o(be_n),
    .din_i(din), .wait_ni(wait_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int k, input int idx);
    return DW'(k * 16'h0123 + idx * 7 + 16'h0F00);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int idx = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk({cs_n, rd_n, wr_n, busy, done, dout_en} == {4'hF, 1'b1, 1'b1, 3'b000},
        "R11 reset pins", {cs_n, rd_n, wr_n, busy, done, dout_en}, {4'hF, 5'b11000});
    rst_ni = 1'b1;
    @(negedge clk);
    chk({cs_n, busy, done} == {4'hF, 2'b00}, "R11 after reset", {cs_n, busy, done}, {4'hF, 2'b00});

    for (int th = 0; th < 2; th++)
      for (int pw = 0; pw < 8; pw++)
        for (int cx = 0; cx < 4; cx++)
          for (int w = 0; w < 2; w++)
            for (int ew = 0; ew < 3; ew++) begin
              int lead, s_len, trail, tot, a;
              logic [AW-1:0] e_addr;
              logic [DW-1:0] e_wd, e_rd;
              logic [BEW-1:0] e_be;
              logic [N_AREA-1:0] e_cs;
              a = idx % N_AREA;
              lead  = (cx >= 2) ? 1 : 0;
              trail = (cx >= 1) ? 1 : 0;
              s_len = th ? (3 + pw + ew) : 2;  // R2/R3/R4
              tot   = lead + s_len + trail;
              e_addr = AW'(idx * 131 + 7);
              e_wd   = ~DW'(idx * 53);
              e_be   = BEW'(idx + 1);
              e_cs   = ~(N_AREA'(1) << a);
              e_rd   = pat(lead + s_len, idx);
              // issue (at done negedge of previous access: R9 back-to-back)
              cfg_three[a] = 1'(th);
              cfg_wait[a*3 +: 3] = 3'(pw);
              cfg_csx[a*2 +: 2] = 2'(cx);
              req = 1'b1; area = 2'(a); addr = e_addr; we = 1'(w);
              wdata = e_wd; be = e_be; wait_n = 1'b1;
              @(posedge clk);
              for (int k = 1; k <= tot; k++) begin
                int s;
                bit strb;
                @(negedge clk);
                s = k - lead;
                strb = (s >= 1) && (s <= s_len);
                chk(cs_n == e_cs, "R6 chip select", cs_n, e_cs);
                chk(busy && !done, "R1 busy during access", {busy, done}, 2'b10);
                chk(rd_n == !(strb && !w), "R5 read strobe window", rd_n, !(strb && !w));
                chk(wr_n == !(strb && w), "R5 write strobe window", wr_n, !(strb && w));
                chk({addr_bus, dout, be_n, dout_en} == {e_addr, e_wd, ~e_be, 1'(w)},
                    "R8 bus hold", {addr_bus, dout, be_n, dout_en}, {e_addr, e_wd, ~e_be, 1'(w)});
                if (k == 1) begin
                  // R1 request while busy ignored; R10 config scramble
                  area = 2'((a + 1) % N_AREA);
                  cfg_three = ~cfg_three; cfg_wait = ~cfg_wait; cfg_csx = ~cfg_csx;
                end else req = 1'b0;
                din = pat(k, idx);
                if (th) wait_n = !((s == 1) || (s >= 3 + pw && s < 3 + pw + ew));  // R4
                else    wait_n = (ew == 0);                                        // R2
              end
              @(posedge clk);
              @(negedge clk);
              chk(done && !busy && cs_n == '1, "R9 done pulse", {done, busy, cs_n}, {2'b10, 4'hF});
              chk(dout_en == 1'b0, "R8 drive off", dout_en, 1'b0);
              if (!w) chk(rdata == e_rd, "R7 read capture", rdata, e_rd);
              wait_n = 1'b1;
              idx++;
            end
    req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(!done && !busy && cs_n == '1, "R9 single pulse", {done, busy, cs_n}, {2'b00, 4'hF});
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule